// File: doc/BRIEF.md
# I2C Register-Bank Target

This block lets an external two-wire bus controller read and write a bank of byte-wide registers that sit outside the block. It watches the open-drain clock and data lines, recognises start, repeated-start and stop conditions, and responds only when the 7-bit address in the first byte of a transfer matches its configured device address. Both lines are driven through output-enable pins: a high enable pulls the line low, and a low enable lets it float.

In a write transfer, the first byte after the address selects a register pointer. Every byte after that is stored at the pointer, and the pointer then moves to the next register. A read begins with a short write transfer that only loads the pointer. After a repeated start and the address with the read flag set, the target returns the register at the pointer and steps the pointer after each byte. The controller acknowledges every byte it wants followed by another, and ends with a not-acknowledge and a stop.

Every register access goes through a request/acknowledge port. While a request is outstanding, the target holds the clock line low, so the register side can take as many cycles as it needs. The pointer keeps its value across stop and start conditions.

Top module: `i2c_regbank_target`

## Requirements
- R1: When bits [7:1] of the first byte after a start equal the device address, the target pulls SDA low during the ninth clock, and SDA stays low and unchanged for the whole high phase of that clock.
- R2: When the address bits do not match, the target leaves SDA released during the ninth clock. It makes no register request and drives neither line until the next start or repeated start.
- R3: With bit 0 of the address byte at 0 (write), the second byte loads the pointer from its lower 7 bits, and bit 7 is ignored. Each following byte is written to the register the pointer selects.
- R4: After each written byte, the pointer advances by one, and it wraps from 0x7F to 0x00.
- R5: After a repeated start and the address with bit 0 at 1 (read), the target shifts out the register at the pointer, MSB first. It advances the pointer after each byte, and a controller ACK (SDA low in the ninth clock) brings the next register.
- R6: A controller NACK (SDA high in the ninth clock) ends the read. No further register request is made, and SDA stays released until the next start.
- R7: While a register request is outstanding, the target holds SCL low and keeps the request, direction, address and write data unchanged. It releases SCL in the cycle after the acknowledge.
- R8: Stop and start conditions leave the pointer unchanged, so a read that skips the pointer phase continues from where the last transfer ended.
- R9: After reset and after a stop, both line enables are low and no register request is pending.
- R10: The target acknowledges the pointer byte and every data byte of a write, as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| scl_oe | output | 1 | Pulls the clock line low when high (stretch) |
| sda_oe | output | 1 | Pulls the data line low when high |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_we | output | 1 | 1 = write, 0 = read for the pending request |
| reg_addr | output | PTR_W | Register index of the pending request |
| reg_wdata | output | 8 | Byte to write |
| reg_ack | input | 1 | One-cycle acknowledge from the register side |
| reg_rdata | input | 8 | Read byte, valid in the acknowledge cycle |

## Verification
The assertions assume that each SCL high phase lasts at least three system clocks, so the synchroniser delay never reaches into a high phase. They also assume that the register side raises its acknowledge only while a request is pending, and for a single cycle. The bench controller keeps both phases of SCL at ten system clocks and changes SDA only in the middle of the low phase. It waits for the clock line to read high before it times a high phase, which respects stretching. The bench register model acknowledges after a random or forced delay, always as a single pulse against a pending request.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_WR_WAIT,
    ST_RD_FETCH,
    ST_RD_SEND,
    ST_RD_MACK,
    ST_IGNORE
  } tgt_state_t;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int LINES = 2,
  parameter int STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // data edges only count as conditions while the clock stays high
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_reg_ptr.sv
module i2ct_reg_ptr #(
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;   // natural wrap at the top
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2ct_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ADDR = 7'h2A,
  parameter int PTR_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              reg_req,
  output logic              reg_we,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr;
  logic ptr_load, ptr_inc;

  tgt_state_t state, ack_next;
  logic [BYTE_W-1:0] rx, tx;
  logic [CNT_W-1:0]  bit_cnt;
  logic              mack;

  i2ct_line_sync #(.LINES(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .dout({scl_s, sda_s})
  );

  i2ct_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  assign ptr_load = (state == ST_PTR) && scl_fall && (bit_cnt == CNT_FULL)
                    && !start_det && !stop_det;
  assign ptr_inc  = reg_req && reg_ack;

  i2ct_reg_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (ptr_load),
    .load_val(rx[PTR_W-1:0]),
    .inc     (ptr_inc),
    .ptr     (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rx        <= '0;
      tx        <= '0;
      bit_cnt   <= '0;
      mack      <= 1'b0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      reg_req <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      reg_req <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && bit_cnt != CNT_FULL) begin
            rx      <= {rx[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == CNT_FULL) begin
            case (state)
              ST_ADDR: begin
                if (rx[BYTE_W-1:1] == DEV_ADDR) begin
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  ack_next <= rx[0] ? ST_RD_FETCH : ST_PTR;
                end else begin
                  state <= ST_IGNORE;
                end
              end
              ST_PTR: begin
                sda_oe   <= 1'b1;
                state    <= ST_ACK;
                ack_next <= ST_WDATA;
              end
              default: begin
                state     <= ST_WR_WAIT;
                scl_oe    <= 1'b1;
                reg_req   <= 1'b1;
                reg_we    <= 1'b1;
                reg_addr  <= ptr;
                reg_wdata <= rx;
              end
            endcase
          end
        end

        ST_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ack_next;
            if (ack_next == ST_RD_FETCH) begin
              scl_oe   <= 1'b1;
              reg_req  <= 1'b1;
              reg_we   <= 1'b0;
              reg_addr <= ptr;
            end
          end
        end

        ST_WR_WAIT: begin
          if (reg_ack) begin
            reg_req  <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b1;
            state    <= ST_ACK;
            ack_next <= ST_WDATA;
          end
        end

        ST_RD_FETCH: begin
          if (reg_ack) begin
            reg_req <= 1'b0;
            scl_oe  <= 1'b0;
            tx      <= reg_rdata;
            sda_oe  <= ~reg_rdata[BYTE_W-1];
            bit_cnt <= '0;
            state   <= ST_RD_SEND;
          end
        end

        ST_RD_SEND: begin
          if (scl_fall) begin
            if (bit_cnt == CNT_LAST) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_MACK;
            end else begin
              tx      <= tx << 1;
              sda_oe  <= ~tx[BYTE_W-2];
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end

        ST_RD_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state    <= ST_RD_FETCH;
              scl_oe   <= 1'b1;
              reg_req  <= 1'b1;
              reg_we   <= 1'b0;
              reg_addr <= ptr;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end

        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker
  import i2ct_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              reg_req,
  input logic              reg_we,
  input logic [PTR_W-1:0]  reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              reg_ack
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata))) // R7
    else $error("request changed before acknowledge");

  AST_REQ_STRETCH: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> scl_oe) // R7
    else $error("request pending without clock stretch");

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_ack) |=> (!reg_req && !scl_oe)) // R7
    else $error("clock not released after acknowledge");

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && $past(scl_i, 2)) |-> $stable(sda_oe)) // R1
    else $error("data drive changed while clock high");
endmodule

bind i2c_regbank_target i2ct_checker #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .reg_req  (reg_req),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_ack  (reg_ack)
);

// File: tb/i2c_regbank_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regbank_target_tb_top;
  localparam logic [6:0] DEV = 7'h2A;
  localparam logic [6:0] BAD = 7'h13;
  localparam int HALF = 10;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, reg_req, reg_we, reg_ack;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic scl_line, sda_line;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_regbank_target #(.DEV_ADDR(DEV)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  int checks = 0, errors = 0, cyc = 0, max_stretch = 0, lat_fixed = -1, acc_cnt = 0;
  bit done = 0;
  logic [7:0] bank_mem [128];
  logic [7:0] exp_mem [128];
  logic [7:0] wbuf [8];
  logic [6:0] exp_ptr = '0;
  logic bank_busy;
  int bank_cnt;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // register-side model: single-pulse acknowledge after a delay
  always @(posedge clk) begin
    if (rst) begin
      reg_ack <= 1'b0; reg_rdata <= '0; bank_busy <= 1'b0; bank_cnt <= 0; acc_cnt <= 0;
      for (int i = 0; i < 128; i++) bank_mem[i] <= init_val(i);
    end else begin
      reg_ack <= 1'b0;
      if (reg_req && !reg_ack) begin
        if (!bank_busy) begin
          bank_busy <= 1'b1;
          bank_cnt <= (lat_fixed >= 0) ? lat_fixed : int'($urandom_range(0, 6));
        end else if (bank_cnt == 0) begin
          reg_ack <= 1'b1; bank_busy <= 1'b0; acc_cnt <= acc_cnt + 1;
          if (reg_we) bank_mem[reg_addr] <= reg_wdata;
          reg_rdata <= bank_mem[reg_addr];
        end else bank_cnt <= bank_cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_scl_high();
    int waited = 0;
    tick(1);
    while (!scl_line && waited < 5000) begin waited++; tick(1); end
    if (waited > max_stretch) max_stretch = waited;
  endtask

  task automatic clock_bit(input bit drv, output bit s_first, output bit s_last);
    m_sda_low = !drv; tick(Q);
    m_scl_low = 1'b0; wait_scl_high();
    tick(2); s_first = sda_line;
    tick(HALF - 3); s_last = sda_line;
    m_scl_low = 1'b1; tick(HALF - Q);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(Q);
    m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
    m_sda_low = 1'b1; tick(HALF);
    m_scl_low = 1'b1; tick(HALF - Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(Q);
    m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
    m_sda_low = 1'b0; tick(2 * HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output bit steady);
    bit f, l;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], f, l);
    clock_bit(1'b1, f, l);
    acked = !f && !l;
    steady = (f == l);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit f, l;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, f, l); d[i] = l; end
    clock_bit(!give_ack, f, l);
  endtask

  task automatic do_write(input logic [7:0] pb, input int n);
    bit a, s;
    bus_start();
    send_byte({DEV, 1'b0}, a, s);
    chk(a && s, "R1 address ack", {a, s}, 2'b11);
    send_byte(pb, a, s);
    chk(a, "R10 pointer ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a, s);
      chk(a && s, "R10 data ack", {a, s}, 2'b11);
      exp_mem[7'(pb[6:0] + i)] = wbuf[i];
    end
    bus_stop();
    exp_ptr = 7'(pb[6:0] + n);
    tick(4);
    for (int i = 0; i < n; i++)
      chk(bank_mem[7'(pb[6:0] + i)] == exp_mem[7'(pb[6:0] + i)], "R3/R4 stored byte",
          bank_mem[7'(pb[6:0] + i)], exp_mem[7'(pb[6:0] + i)]);
  endtask

  task automatic do_read(input bit set_ptr, input logic [7:0] pb, input int n, input string tag);
    bit a, s;
    logic [7:0] d;
    logic [6:0] p;
    int acc0;
    bus_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, a, s);
      send_byte(pb, a, s);
      exp_ptr = pb[6:0];
      bus_start();
    end
    acc0 = acc_cnt;
    p = exp_ptr;
    send_byte({DEV, 1'b1}, a, s);
    chk(a && s, "R1 read address ack", {a, s}, 2'b11);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d == exp_mem[7'(p + i)], tag, d, exp_mem[7'(p + i)]);
    end
    chk(!sda_oe, "R6 SDA released after NACK", sda_oe, 0);
    bus_stop();
    tick(20);
    chk(acc_cnt - acc0 == n, "R6 no fetch after NACK", acc_cnt - acc0, n);
    exp_ptr = 7'(p + n);
  endtask

  initial begin
    bit a, s;
    int acc0;
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    tick(6);
    chk(!scl_oe && !sda_oe && !reg_req, "R9 reset state", {scl_oe, sda_oe, reg_req}, 0);
    rst = 1'b0;
    tick(10);
    chk(!scl_oe && !sda_oe && !reg_req, "R9 idle after reset", {scl_oe, sda_oe, reg_req}, 0);

    // directed burst write then read back with repeated start
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
    do_write(8'h05, 3);
    chk(!scl_oe && !sda_oe, "R9 released after stop", {scl_oe, sda_oe}, 0);
    do_read(1'b1, 8'h05, 3, "R5 read burst");

    // pointer bit 7 is ignored (R3)
    wbuf[0] = 8'h77;
    do_write(8'h85, 1);
    chk(bank_mem[5] == 8'h77, "R3 pointer MSB ignored", bank_mem[5], 8'h77);

    // wrap from 0x7F to 0x00 (R4), then resume without pointer phase (R8)
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h7E, 3);
    chk(bank_mem[0] == 8'h33, "R4 wrap to 0x00", bank_mem[0], 8'h33);
    do_read(1'b0, 8'h00, 2, "R8 pointer kept across stop");

    // address mismatch (R2)
    acc0 = acc_cnt;
    bus_start();
    send_byte({BAD, 1'b0}, a, s);
    chk(!a, "R2 no ack on mismatch", a, 0);
    send_byte(8'h10, a, s);
    chk(!a, "R2 following byte ignored", a, 0);
    send_byte(8'h99, a, s);
    bus_stop();
    tick(10);
    chk(acc_cnt == acc0, "R2 no register access", acc_cnt, acc0);
    do_read(1'b0, 8'h00, 1, "R2 pointer untouched by foreign transfer");

    // slow register side forces stretching (R7)
    lat_fixed = 40; max_stretch = 0;
    wbuf[0] = 8'h5A;
    do_write(8'h30, 1);
    chk(max_stretch >= 30, "R7 clock held during write", max_stretch, 30);
    max_stretch = 0;
    do_read(1'b1, 8'h30, 2, "R7 read under stretch");
    chk(max_stretch >= 30, "R7 clock held during read", max_stretch, 30);
    lat_fixed = -1;

    // random traffic
    for (int it = 0; it < 10; it++) begin
      int n;
      logic [7:0] pb;
      n = int'($urandom_range(1, 4));
      pb = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) begin
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom_range(0, 255));
        do_write(pb, n);
      end else begin
        do_read(1'b1, pb, n, "R5 random read");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule